// File: doc/BRIEF.md
# Four-Bank DDR SDRAM Command Sequencer

This block sits between a simple host port and the command pins of a double-data-rate SDRAM with four banks. The host presents a request (bank, row, column, direction, burst code, and whether to close the row afterwards) and holds it until the block grants it. The block remembers which row is open in each bank. It emits the shortest legal command sequence for the request: a column command alone on a row hit; ACTIVE then column on a closed bank; PRECHARGE, ACTIVE, column on a row conflict. Per-bank down-counters enforce activate-to-column, precharge and refresh-cycle times. A shared counter keeps column commands apart by the data-bus occupancy of the previous burst.

A refresh timer raises a pending flag every `REF_INTERVAL` cycles. The flag is served between requests: open banks are closed with a precharge-all command, then AUTO REFRESH is issued. For reads, a shift register produces the host data-valid strobe after the fixed CAS latency, for as many cycles as the burst occupies on the bus.

The control is one state machine with three states. `ST_IDLE` waits and picks work, with refresh first. `ST_ACCESS` issues one command per cycle towards the held request and returns to `ST_IDLE` on the column command. `ST_REFRESH` precharges open banks and returns to `ST_IDLE` on the refresh command. The transitions are: IDLE→REFRESH when refresh is pending; IDLE→ACCESS when a request is valid; ACCESS→IDLE on the column command, or when the request is withdrawn; REFRESH→IDLE on the refresh command.

Top module: `ddr_bank_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mem_cmd` is NOP, `req_ready` and `rd_valid` are 0, and every bank is closed.
- R2: `mem_cmd` is {cs_n, ras_n, cas_n, we_n}. The legal codes are NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010 and REFRESH 0001. At most one command is issued per cycle, and none is issued while no request and no refresh is pending.
- R3: A request to a closed bank issues ACTIVE with the row on `mem_addr` and the bank on `mem_bank`. The column command follows no fewer than `T_RCD` cycles later, with the column on `mem_addr[COL_W-1:0]` and `mem_addr[10]` equal to the auto-precharge flag.
- R4: A request to a bank whose open row equals the requested row issues only the column command, with no ACTIVE and no PRECHARGE.
- R5: A request to a bank with a different open row issues PRECHARGE to that bank with `mem_addr[10]`=0, then ACTIVE no fewer than `T_RP` cycles later, then the column command.
- R6: A column command with auto precharge closes its bank. The next request to that bank issues ACTIVE without PRECHARGE, no fewer than B+`T_RP` cycles after that column command (B = burst cycles).
- R7: `req_burst` 0 means 2 beats (B=1 cycle), 1 means 4 beats (B=2), and 2 or 3 means 8 beats (B=4). A column command comes no fewer than B cycles after the previous one, where B is the previous burst's value.
- R8: For a READ visible on `mem_cmd` in cycle j, `rd_valid` is 1 in exactly cycles j+`CL` through j+`CL`+B-1. A WRITE never raises `rd_valid`.
- R9: Refresh becomes pending every `REF_INTERVAL` cycles and is served between requests. If any bank is open, a PRECHARGE with `mem_addr[10]`=1 comes first and REFRESH follows no fewer than `T_RP` cycles later. After REFRESH, no ACTIVE is issued for `T_RFC` cycles.
- R10: `req_ready` is 1 for exactly the one cycle in which the request's column command appears on `mem_cmd`.
- R11: Banks are independent: activity on other banks leaves an open row open, so a later same-row request to it is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after this burst |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_burst | input | 2 | Burst code (see R7) |
| req_ready | output | 1 | Grant, one cycle, with the column command |
| rd_valid | output | 1 | Read data valid strobe |
| mem_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| mem_bank | output | BANK_W | Bank address to memory |
| mem_addr | output | ROW_W | Row / column address to memory |

## Verification
The bench targets the row hit, miss and closed cases in an order where each depends on the state left by the one before. If open-row tracking were wrong, a hit would show a spurious ACTIVE, or a conflict would go out without its PRECHARGE. Column commands placed back to back with short and long bursts would expose a bus spacing or strobe length that ignores the burst code, code 3 included. Read strobes are compared cycle by cycle, so an off-by-one latency or a strobe raised by a write would show. Refresh is caught with banks open and again with all banks closed. A controller that skipped the precharge-all, precharged needlessly, or activated inside the refresh cycle time would be flagged.

// File: rtl/ddr_ctrl_pkg.sv
package ddr_ctrl_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } ddr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_REFRESH
    } ctl_state_e;

    // bus cycles taken by one burst: code 0 -> 1, 1 -> 2, 2/3 -> 4
    function automatic logic [2:0] burst_cycles(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
    parameter int ROW_W = 11,
    parameter int CNT_W = 4,
    parameter int T_RCD = 2,
    parameter int T_RP  = 3,
    parameter int T_RFC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_col,
    input  logic             col_ap,
    input  logic [2:0]       col_len,
    input  logic             do_pre,
    input  logic             do_ref,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             act_ok,
    output logic             col_ok,
    output logic             pre_ok
);

    logic [CNT_W-1:0] act_cnt, col_cnt, pre_cnt;

    assign act_ok = (act_cnt == '0);
    assign col_ok = (col_cnt == '0);
    assign pre_ok = (pre_cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
            act_cnt  <= '0;
            col_cnt  <= '0;
            pre_cnt  <= '0;
        end else begin
            if (act_cnt != '0) act_cnt <= act_cnt - 1'b1;
            if (col_cnt != '0) col_cnt <= col_cnt - 1'b1;
            if (pre_cnt != '0) pre_cnt <= pre_cnt - 1'b1;
            if (do_act) begin
                is_open  <= 1'b1;
                open_row <= act_row;
                col_cnt  <= CNT_W'(T_RCD - 1);
                pre_cnt  <= CNT_W'(T_RCD - 1);
            end
            if (do_col) begin
                pre_cnt <= CNT_W'(int'(col_len) - 1);
                if (col_ap) begin
                    is_open <= 1'b0;
                    act_cnt <= CNT_W'(int'(col_len) + T_RP - 1);
                end
            end
            if (do_pre) begin
                is_open <= 1'b0;
                act_cnt <= CNT_W'(T_RP - 1);
            end
            if (do_ref) act_cnt <= CNT_W'(T_RFC - 1);
        end
    end

    // R3: activate only a closed bank whose precharge/refresh time is over
    a_r3_act_on_closed: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (!is_open && act_ok));
    // R4: column command only to an open row after the activate delay
    a_r4_col_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        do_col |-> (is_open && col_ok));
    // R5: precharge never cuts a running burst short
    a_r5_pre_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |-> pre_ok);

endmodule

// File: rtl/ddr_ref_tick.sv
module ddr_ref_tick #(
    parameter int REF_INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic served,
    output logic pending
);

    localparam int TW = $clog2(REF_INTERVAL + 1);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= TW'(REF_INTERVAL - 1);
            pending <= 1'b0;
        end else begin
            if (served) pending <= 1'b0;
            if (cnt == '0) begin
                cnt     <= TW'(REF_INTERVAL - 1);
                pending <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R9: a pending refresh is kept until it is served
    a_r9_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !served) |=> pending);

endmodule

// File: rtl/ddr_rd_pipe.sv
module ddr_rd_pipe #(
    parameter int CL   = 3,
    parameter int MAXB = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] len,
    output logic       valid
);

    localparam int SR_W = CL + MAXB;
    logic [SR_W-1:0] sr;
    logic [SR_W-1:0] mask;

    assign mask  = SR_W'((SR_W'(1) << len) - SR_W'(1)) << CL;
    assign valid = sr[0];

    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= (sr >> 1) | (load ? mask : '0);
    end

    // R8: a new read window never lands on one still in flight
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (((sr >> 1) & mask) == '0));

endmodule

// File: rtl/ddr_bank_ctrl.sv
module ddr_bank_ctrl
    import ddr_ctrl_pkg::*;
#(
    parameter int ROW_W        = 11,
    parameter int COL_W        = 8,
    parameter int BANKS        = 4,
    parameter int CL           = 3,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 3,
    parameter int T_RFC        = 8,
    parameter int REF_INTERVAL = 1560,
    localparam int BANK_W      = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [1:0]        req_burst,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [3:0]        mem_cmd,
    output logic [BANK_W-1:0] mem_bank,
    output logic [ROW_W-1:0]  mem_addr
);

    localparam int AP_BIT = 10;
    localparam int MAXA   = (T_RFC > T_RP + 4) ? T_RFC : T_RP + 4;
    localparam int MAXT   = (MAXA > T_RCD) ? MAXA : T_RCD;
    localparam int CNT_W  = $clog2(MAXT + 1);

    ctl_state_e state, nxt_state;

    logic [BANKS-1:0] is_open, act_ok, col_ok, pre_ok;
    logic [ROW_W-1:0] open_row [BANKS];

    logic issue_act, issue_col, issue_pre, issue_prea, issue_ref;
    ddr_cmd_e         nxt_cmd;
    logic [ROW_W-1:0] nxt_addr;
    logic [2:0]       blen;
    logic [2:0]       bus_cnt;
    logic             ref_pending;
    logic             pre_all_ok;

    assign blen       = burst_cycles(req_burst);
    assign pre_all_ok = &(pre_ok | ~is_open);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (req_bank == BANK_W'(b));
        ddr_bank_track #(
            .ROW_W(ROW_W), .CNT_W(CNT_W),
            .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
        ) i_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .do_act  (issue_act && sel),
            .do_col  (issue_col && sel),
            .col_ap  (req_autopre),
            .col_len (blen),
            .do_pre  ((issue_pre && sel) || (issue_prea && is_open[b])),
            .do_ref  (issue_ref),
            .act_row (req_row),
            .is_open (is_open[b]),
            .open_row(open_row[b]),
            .act_ok  (act_ok[b]),
            .col_ok  (col_ok[b]),
            .pre_ok  (pre_ok[b])
        );
    end

    ddr_ref_tick #(.REF_INTERVAL(REF_INTERVAL)) i_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .served (issue_ref),
        .pending(ref_pending)
    );

    ddr_rd_pipe #(.CL(CL), .MAXB(4)) i_rdp (
        .clk  (clk),
        .rst_n(rst_n),
        .load (issue_col && !req_write),
        .len  (blen),
        .valid(rd_valid)
    );

    // next state and next command
    always_comb begin
        nxt_state  = state;
        nxt_cmd    = CMD_NOP;
        nxt_addr   = '0;
        issue_act  = 1'b0;
        issue_col  = 1'b0;
        issue_pre  = 1'b0;
        issue_prea = 1'b0;
        issue_ref  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_pending)    nxt_state = ST_REFRESH;
                else if (req_valid) nxt_state = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (!req_valid) begin
                    nxt_state = ST_IDLE;
                end else if (is_open[req_bank]) begin
                    if (open_row[req_bank] == req_row) begin
                        if (col_ok[req_bank] && bus_cnt == '0) begin
                            issue_col              = 1'b1;
                            nxt_cmd                = req_write ? CMD_WR : CMD_RD;
                            nxt_addr[COL_W-1:0]    = req_col;
                            nxt_addr[AP_BIT]       = req_autopre;
                            nxt_state              = ST_IDLE;
                        end
                    end else if (pre_ok[req_bank]) begin
                        issue_pre = 1'b1;
                        nxt_cmd   = CMD_PRE;
                    end
                end else if (act_ok[req_bank]) begin
                    issue_act = 1'b1;
                    nxt_cmd   = CMD_ACT;
                    nxt_addr  = req_row;
                end
            end
            ST_REFRESH: begin
                if (|is_open) begin
                    if (pre_all_ok) begin
                        issue_prea       = 1'b1;
                        nxt_cmd          = CMD_PRE;
                        nxt_addr[AP_BIT] = 1'b1;
                    end
                end else if (&act_ok) begin
                    issue_ref = 1'b1;
                    nxt_cmd   = CMD_REF;
                    nxt_state = ST_IDLE;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // output and bus-occupancy registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cmd   <= CMD_NOP;
            mem_bank  <= '0;
            mem_addr  <= '0;
            req_ready <= 1'b0;
            bus_cnt   <= '0;
        end else begin
            mem_cmd   <= nxt_cmd;
            mem_bank  <= req_bank;
            mem_addr  <= nxt_addr;
            req_ready <= issue_col;
            if (issue_col)           bus_cnt <= blen - 3'd1;
            else if (bus_cnt != '0)  bus_cnt <= bus_cnt - 3'd1;
        end
    end

    // R2: never more than one command decided in a cycle
    a_r2_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_act, issue_col, issue_pre, issue_prea, issue_ref}));
    // R9: refresh only with every bank closed
    a_r9_ref_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ref |-> (is_open == '0));
    // R10: grant travels with a column command
    a_r10_ready_with_col: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cmd == CMD_RD || mem_cmd == CMD_WR));
    // R7: two column commands are never in adjacent cycles on a long burst
    a_r7_bus_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && bus_cnt != '0) |-> !issue_col);

endmodule

// File: tb/test_ddr_bank_ctrl.sv
`timescale 1ns/1ps
module test_ddr_bank_ctrl;

    localparam int CL = 3, T_RCD = 2, T_RP = 3, T_RFC = 8, REF_INT = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0]  req_bank = '0, req_burst = '0;
    logic [10:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic        req_ready, rd_valid;
    logic [3:0]  mem_cmd;
    logic [1:0]  mem_bank;
    logic [10:0] mem_addr;

    always #2 clk = ~clk;

    ddr_bank_ctrl #(.CL(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
                    .REF_INTERVAL(REF_INT)) i_ddr_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_autopre(req_autopre), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_burst(req_burst), .req_ready(req_ready),
        .rd_valid(rd_valid), .mem_cmd(mem_cmd), .mem_bank(mem_bank),
        .mem_addr(mem_addr));

    int n_checks = 0, n_err = 0;
    int cyc = 0;
    bit started = 0;
    int n_act = 0, n_pre = 0, n_ref = 0;
    int act_t [4];
    int act_row [4];
    int pre_t = 0, ref_t = 0;
    bit pre_all = 0;
    bit exp_rv [64];

    function automatic int blen(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // command / strobe monitor
    always @(negedge clk) begin
        if (started) begin
            cyc++;
            chk(rd_valid == exp_rv[cyc % 64], "R8 rd_valid window",
                int'(rd_valid), int'(exp_rv[cyc % 64]));
            exp_rv[cyc % 64] = 1'b0;
            case (mem_cmd)
                4'b0111: ;
                4'b0011: begin n_act++; act_t[mem_bank] = cyc; act_row[mem_bank] = mem_addr; end
                4'b0010: begin n_pre++; pre_t = cyc; pre_all = mem_addr[10]; end
                4'b0101: for (int k = 0; k < blen(req_burst); k++) exp_rv[(cyc + CL + k) % 64] = 1'b1;
                4'b0100: ;
                4'b0001: begin n_ref++; ref_t = cyc; end
                default: chk(1'b0, "R2 legal command", int'(mem_cmd), 7);
            endcase
        end
    end

    // watchdog
    initial begin
        #(4 * 30000);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    int  prev_col_t = -100, prev_len = 0;
    bit  ap_pend [4];
    int  ap_t [4];
    int  ap_len [4];

    task automatic do_req(input logic w, input logic ap, input logic [1:0] b,
                          input logic [10:0] r, input logic [7:0] c, input logic [1:0] bu,
                          input int exp_pre, input int exp_act);
        int a0, p0, guard;
        a0 = n_act; p0 = n_pre; guard = 0;
        req_write = w; req_autopre = ap; req_bank = b; req_row = r;
        req_col = c; req_burst = bu; req_valid = 1'b1;
        do begin
            @(negedge clk); #1;
            guard++;
        end while (!req_ready && guard < 300);
        chk(mem_cmd == (w ? 4'b0100 : 4'b0101), "R10 grant with column cmd", int'(mem_cmd), w ? 4 : 5);
        chk(mem_addr[7:0] == c && mem_bank == b, "R3 column address/bank", int'(mem_addr[7:0]), int'(c));
        chk(mem_addr[10] == ap, "R3 auto precharge bit", int'(mem_addr[10]), int'(ap));
        chk(n_pre - p0 == exp_pre, "R4/R5 precharge count", n_pre - p0, exp_pre);
        chk(n_act - a0 == exp_act, "R3/R4 activate count", n_act - a0, exp_act);
        if (exp_act == 1) begin
            chk(act_row[b] == int'(r), "R3 activate row", act_row[b], int'(r));
            chk(cyc - act_t[b] >= T_RCD, "R3 activate-to-column", cyc - act_t[b], T_RCD);
            if (exp_pre == 1)
                chk(act_t[b] - pre_t >= T_RP, "R5 precharge-to-activate", act_t[b] - pre_t, T_RP);
            if (ap_pend[b])
                chk(act_t[b] - ap_t[b] >= ap_len[b] + T_RP, "R6 auto precharge recovery",
                    act_t[b] - ap_t[b], ap_len[b] + T_RP);
        end
        chk(cyc - prev_col_t >= prev_len, "R7 column spacing", cyc - prev_col_t, prev_len);
        req_valid = 1'b0;
        @(negedge clk); #1;
        chk(req_ready == 1'b0, "R10 single-cycle grant", int'(req_ready), 0);
        prev_col_t = cyc - 1; prev_len = blen(bu);
        ap_pend[b] = ap; ap_t[b] = cyc - 1; ap_len[b] = blen(bu);
    endtask

    // write, ap, bank, row, col, burst, exp_pre, exp_act
    localparam logic [26:0] VEC [9] = '{
        {1'b0, 1'b0, 2'd0, 11'd5,    8'd3,   2'd1, 1'b0, 1'b1},  // R3 closed bank
        {1'b1, 1'b0, 2'd0, 11'd5,    8'd8,   2'd0, 1'b0, 1'b0},  // R4 hit
        {1'b0, 1'b1, 2'd1, 11'd9,    8'd1,   2'd2, 1'b0, 1'b1},  // R6 ap read BL8
        {1'b0, 1'b0, 2'd0, 11'd5,    8'd16,  2'd2, 1'b0, 1'b0},  // R11 bank0 still open
        {1'b1, 1'b1, 2'd0, 11'd7,    8'd2,   2'd1, 1'b1, 1'b1},  // R5 miss
        {1'b0, 1'b0, 2'd1, 11'd9,    8'd4,   2'd0, 1'b0, 1'b1},  // R6 closed by ap
        {1'b0, 1'b0, 2'd2, 11'd100,  8'd255, 2'd3, 1'b0, 1'b1},  // R7 code 3
        {1'b0, 1'b0, 2'd0, 11'd7,    8'd0,   2'd0, 1'b0, 1'b1},  // R6 bank0 closed
        {1'b1, 1'b0, 2'd3, 11'd2047, 8'd5,   2'd1, 1'b0, 1'b1}   // R3 top row
    };

    initial begin
        int n0, p0, r0, r1, g;
        repeat (3) @(negedge clk);
        #1;
        chk(mem_cmd == 4'b0111, "R1 reset command NOP", int'(mem_cmd), 7);
        chk(req_ready == 1'b0 && rd_valid == 1'b0, "R1 reset outputs low", int'(req_ready), 0);
        rst_n = 1'b1;
        started = 1'b1;
        @(negedge clk); #1;
        chk(mem_cmd == 4'b0111, "R1 NOP after reset", int'(mem_cmd), 7);

        // idle: no request, no command (R2)
        n0 = n_act + n_pre + n_ref;
        repeat (20) @(negedge clk);
        #1;
        chk(n_act + n_pre + n_ref == n0, "R2 no command when idle", n_act + n_pre + n_ref - n0, 0);

        for (int i = 0; i < 9; i++) begin
            logic [26:0] v;
            v = VEC[i];
            do_req(v[26], v[25], v[24:23], v[22:12], v[11:4], v[3:2], int'(v[1]), int'(v[0]));
        end
        repeat (12) @(negedge clk);
        #1;

        // R9: first refresh with banks open
        p0 = n_pre; r0 = n_ref; g = 0;
        while (n_ref == r0 && g < 1000) begin @(negedge clk); #1; g++; end
        chk(n_ref == r0 + 1, "R9 refresh issued", n_ref - r0, 1);
        chk(ref_t <= REF_INT + 20, "R9 refresh interval met", ref_t, REF_INT + 20);
        chk(n_pre > p0 && pre_all == 1'b1, "R9 precharge-all before refresh", int'(pre_all), 1);
        chk(ref_t - pre_t >= T_RP, "R9 precharge-to-refresh", ref_t - pre_t, T_RP);
        r1 = ref_t;

        // access right after refresh: bank2 closed by precharge-all
        ap_pend[2] = 1'b0;
        do_req(1'b0, 1'b1, 2'd2, 11'd100, 8'd9, 2'd0, 0, 1);
        chk(act_t[2] - r1 >= T_RFC, "R9 refresh cycle time", act_t[2] - r1, T_RFC);
        repeat (8) @(negedge clk);
        #1;

        // R9: second refresh with all banks closed
        p0 = n_pre; r0 = n_ref; g = 0;
        while (n_ref == r0 && g < 1000) begin @(negedge clk); #1; g++; end
        chk(n_ref == r0 + 1, "R9 second refresh issued", n_ref - r0, 1);
        chk(n_pre == p0, "R9 no precharge with banks closed", n_pre - p0, 0);
        chk((ref_t - r1 >= REF_INT - 12) && (ref_t - r1 <= REF_INT + 12),
            "R9 refresh period", ref_t - r1, REF_INT);
        repeat (5) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule